// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block gathers 32 peripheral request lines per bank and drives one interrupt output per bank toward the processor. A parameter sets how many banks exist. Each bank latches rising edges of its request lines into a status word. It gates that word with a per-bank enable word and raises its output while any enabled source is pending. Software sees each bank through a fixed register window. It clears latched requests by writing ones, and it reads an enable-filtered view to find the source that needs service. A zero in that view means there is nothing to do.

Software reaches the registers over a simple synchronous bus with an address, write data, a write strobe, a read strobe and a registered read-data return. Bank b occupies the byte range starting at b × 0x28. Within a window the registers sit at 0x00 (latched status, write 1 to clear), 0x08 (enable), 0x10 (status AND enable, read-only), 0x18 (software set on write, raw input lines on read) and 0x20 (plain storage word).

Top module: `irq_bank_ctrl`

## Requirements
- R1: A request line that is low in one cycle and high at the next clock edge sets its bit in the bank status register (offset 0x00) at that edge. The bit stays set after the line returns low, until software clears it.
- R2: Writing offset 0x00 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R3: When a rising request and a write-1 clear hit the same bit at the same clock edge, the bit ends up set.
- R4: The enable register at offset 0x08 is fully read/write and is 0 after reset. Offset 0x10 reads status AND enable, so it reads 0 when no enabled source is pending.
- R5: A bank's interrupt output is the OR of its status AND enable value, delayed by one register. It changes one clock edge after the register write that changes that value.
- R6: Writing offset 0x18 sets the status bits whose write-data bits are 1. Reading offset 0x18 returns the bank's request lines as they are at the read edge, not latched.
- R7: Offset 0x20 is a 32-bit read/write word that is 0 after reset. Its contents have no effect on the status, pending view or interrupt output.
- R8: The window of bank b starts at byte address b × 0x28. Accesses in one bank's window leave every other bank unchanged.
- R9: Reads of any address that is not one of the five register offsets of an existing bank return 0, and writes to such addresses change nothing.
- R10: Read data is registered. It appears on the clock edge at which the read strobe is sampled and holds between reads. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NUM_BANKS*32 | Request lines; bank b uses bits [32b+31:32b] |
| irq_out | output | NUM_BANKS | One registered interrupt output per bank |

## Verification
The latch is driven with a single pulse, with software-set words, and with a multi-bit input pattern read both raw and latched. These tell edge capture apart from level following and from raw pass-through. A pulse on a line that is being cleared in the same cycle separates set priority from clear priority. Partial and all-ones clear words show whether a clear touches only the addressed bits. Enable and storage-word patterns, and accesses to a distant bank and to unmapped holes, show whether the gating, the storage word and the decoder affect anything beyond the register they address.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int SRC_W     = 32;
    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 40;   // 0x28 bytes per bank window
    localparam int OFS_W     = 6;

    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_ENA   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_PEND  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_SWREQ = 6'h18;
    localparam logic [OFS_W-1:0] OFS_STORE = 6'h20;

    typedef struct packed {
        logic [SRC_W-1:0] stat;
        logic [SRC_W-1:0] ena;
        logic [SRC_W-1:0] store;
        logic             irq;
    } bank_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_regs_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] rise
);
    logic [SRC_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src;
        rise   = src & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [SRC_W-1:0]  src,
    input  logic [SRC_W-1:0]  rise,
    output logic [DATA_W-1:0] rd_val,
    output logic              hit,
    output logic              irq
);
    localparam logic [ADDR_W:0] BASE_V = BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] WIN_V  = WIN_BYTES[ADDR_W:0];

    bank_regs_t       cur_q, nxt_d;
    logic [ADDR_W:0]  rel;
    logic [OFS_W-1:0] ofs;
    logic             in_win;
    logic [SRC_W-1:0] clr_w, set_w;
    logic             wr_stat;

    always_comb begin
        rel    = {1'b0, addr} - BASE_V;
        in_win = ({1'b0, addr} >= BASE_V) && (rel < WIN_V);
        ofs    = rel[OFS_W-1:0];
        hit    = in_win && (ofs == OFS_STAT || ofs == OFS_ENA || ofs == OFS_PEND ||
                            ofs == OFS_SWREQ || ofs == OFS_STORE);
    end

    always_comb begin
        nxt_d   = cur_q;
        clr_w   = '0;
        set_w   = '0;
        wr_stat = 1'b0;
        if (we && hit) begin
            case (ofs)
                OFS_STAT:  begin clr_w = wdata; wr_stat = 1'b1; end
                OFS_ENA:   nxt_d.ena   = wdata;
                OFS_SWREQ: set_w       = wdata;
                OFS_STORE: nxt_d.store = wdata;
                default:   ;
            endcase
        end
        nxt_d.stat = (cur_q.stat & ~clr_w) | rise | set_w;
        nxt_d.irq  = |(cur_q.stat & cur_q.ena);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        rd_val = '0;
        if (hit) begin
            case (ofs)
                OFS_STAT:  rd_val = cur_q.stat;
                OFS_ENA:   rd_val = cur_q.ena;
                OFS_PEND:  rd_val = cur_q.stat & cur_q.ena;
                OFS_SWREQ: rd_val = src;
                OFS_STORE: rd_val = cur_q.store;
                default:   rd_val = '0;
            endcase
        end
    end

    assign irq = cur_q.irq;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((cur_q.stat & $past(cur_q.stat)) == $past(cur_q.stat))); // R1
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((cur_q.stat & $past(rise)) == $past(rise))); // R3
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_q.ena) == '0) |-> !cur_q.irq); // R5
    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && in_win && ofs == OFS_STORE) |=> $stable(cur_q.store)); // R7
endmodule

// File: rtl/irq_rd_merge.sv
module irq_rd_merge
    import irq_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS*DATA_W-1:0] vals,
    output logic [DATA_W-1:0]           merged
);
    logic [DATA_W-1:0] acc [NUM_BANKS+1];

    assign acc[0] = '0;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_or
        assign acc[b+1] = acc[b] | vals[b*DATA_W +: DATA_W];
    end
    assign merged = acc[NUM_BANKS];
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] irq_src,
    output logic [NUM_BANKS-1:0]       irq_out
);
    localparam int VALS_W = NUM_BANKS * DATA_W;

    logic [VALS_W-1:0]    bank_vals;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [DATA_W-1:0]    merged;
    bus_regs_t            bus_q, bus_d;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [SRC_W-1:0] rise_b;

        irq_edge_detect u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (irq_src[b*SRC_W +: SRC_W]),
            .rise  (rise_b)
        );

        irq_bank_regs #(
            .ADDR_W (ADDR_W),
            .BASE   (b * WIN_BYTES)
        ) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr   (bus_addr),
            .wdata  (bus_wdata),
            .we     (bus_we),
            .src    (irq_src[b*SRC_W +: SRC_W]),
            .rise   (rise_b),
            .rd_val (bank_vals[b*DATA_W +: DATA_W]),
            .hit    (bank_hit[b]),
            .irq    (irq_out[b])
        );
    end

    irq_rd_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
        .vals   (bank_vals),
        .merged (merged)
    );

    always_comb begin
        bus_d = bus_q;
        if (bus_re) bus_d.rdata = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_rdata = bus_q.rdata;

    AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit)); // R8
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bank_hit == '0) |=> (bus_rdata == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/irq_bank_ctrl_bench.sv
`timescale 1ns/1ps
module irq_bank_ctrl_bench;
    localparam int NB = 4;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NB*32-1:0] irq_src = '0;
    logic [NB-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        re_seen = 1'b0;

    always #2.5 clk = ~clk;

    irq_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_irq_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .irq_out   (irq_out)
    );

    // monitor: pops one expected word per sampled read
    always @(posedge clk) re_seen <= bus_re;
    always @(negedge clk) begin
        if (re_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %08h expected %08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic chk_irq(input logic [NB-1:0] e, input string t);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
        end
    endtask

    task automatic chk_rdata(input logic [31:0] e, input string t);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata actual %08h expected %08h", t, bus_rdata, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk_irq(4'b0000, "R10 reset irq");
        chk_rdata(32'h0, "R10 reset rdata");
        rd(8'h00, 32'h0, "R10 reset stat");
        rd(8'h08, 32'h0, "R4 reset enable");
        rd(8'h20, 32'h0, "R7 reset store");

        // R1 pulse latches and sticks
        irq_src[3] = 1'b1;
        @(negedge clk);
        irq_src[3] = 1'b0;
        rd(8'h00, 32'h8, "R1 sticky status");
        rd(8'h10, 32'h0, "R4 pending gated by enable");
        chk_irq(4'b0000, "R4 irq gated");

        // R4/R5 enable and output timing
        wr(8'h08, 32'h8);
        chk_irq(4'b0000, "R5 irq one cycle late");
        @(negedge clk);
        chk_irq(4'b0001, "R5 irq raised");
        rd(8'h08, 32'h8, "R4 enable readback");
        rd(8'h10, 32'h8, "R4 pending view");

        // R2 clear
        wr(8'h00, 32'h8);
        chk_irq(4'b0001, "R5 irq fall lags");
        @(negedge clk);
        chk_irq(4'b0000, "R5 irq dropped");
        rd(8'h00, 32'h0, "R2 cleared");

        // R6 software set, R2 partial and full clear
        wr(8'h18, 32'h21);
        rd(8'h00, 32'h21, "R6 software set");
        wr(8'h00, 32'h01);
        rd(8'h00, 32'h20, "R2 partial clear");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R2 full clear");

        // R6 raw read
        @(negedge clk);
        irq_src[31:0] = 32'hA5;
        rd(8'h18, 32'hA5, "R6 raw lines");
        irq_src[31:0] = 32'h0;
        rd(8'h18, 32'h0, "R6 raw lines low");
        rd(8'h00, 32'hA5, "R1 multi-bit latch");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R2 clear after raw");

        // R3 set wins
        @(negedge clk);
        irq_src[1] = 1'b1;
        bus_addr = 8'h00; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        irq_src[1] = 1'b0;
        rd(8'h00, 32'h2, "R3 set beats clear");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R3 cleanup");

        // R7 storage word has no effect
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'hFFFF_FFFF, "R7 store readback");
        rd(8'h10, 32'h0, "R7 pending unaffected");
        wr(8'h18, 32'h8);
        @(negedge clk);
        chk_irq(4'b0001, "R7 irq follows pending only");
        wr(8'h20, 32'h0);
        @(negedge clk);
        chk_irq(4'b0001, "R7 irq unchanged by store");
        rd(8'h10, 32'h8, "R7 pending unchanged");
        wr(8'h00, 32'h8);
        @(negedge clk);
        chk_irq(4'b0000, "R2 irq cleared");

        // R8 bank decode
        wr(8'h58, 32'h1234);
        rd(8'h08, 32'h8, "R8 bank0 enable untouched");
        rd(8'h58, 32'h1234, "R8 bank2 enable");
        rd(8'h30, 32'h0, "R8 bank1 enable untouched");
        wr(8'h80, 32'h8000_0000);
        irq_src[127] = 1'b1;
        repeat (3) @(negedge clk);
        chk_irq(4'b1000, "R8 bank3 irq only");
        irq_src[127] = 1'b0;
        rd(8'h78, 32'h8000_0000, "R8 bank3 status");
        rd(8'h88, 32'h8000_0000, "R8 bank3 pending");
        rd(8'h00, 32'h0, "R8 bank0 status untouched");

        // R9 unmapped
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R9 hole read");
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R9 hole write ignored");
        wr(8'hA8, 32'hFFFF_FFFF);
        rd(8'hA8, 32'h0, "R9 beyond banks");
        rd(8'hA0, 32'h0, "R9 beyond banks base");
        rd(8'h08, 32'h8, "R9 enable unchanged");

        // R10 hold
        repeat (3) @(negedge clk);
        chk_rdata(32'h8, "R10 rdata holds");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule